// File: doc/BRIEF.md
# Bit-Serial Split-Phase Register File

This block is a small word store for a bit-serial datapath. It keeps eight short words of eighteen bits each and moves exactly one bit per bit period. A 3-bit word select picks the word and a bit-time index picks the bit position. Bit time 0 addresses bit 0, so words stream least significant bit first.

Each bit period begins on a rising clock edge and is split into two halves. During the high half the addressed bit is read out of the array, and the falling edge captures it in the output flip-flop. During the low half the incoming serial bit, normally the result bit of a serial ALU, is prepared. If write enable is set, that bit is committed into the same bit position on the rising edge that closes the period. A bit can therefore be read, combined and written back within one period. The read always returns the value that was stored before that write.

Top module: `serial_regfile_split`

## Requirements
- R1: While `rst_n` is low, `rd_bit` is 0. It clears as soon as reset is asserted, without waiting for a clock edge.
- R2: The store holds eight words of eighteen bits. `word_sel` (0 to 7) picks the word and `bit_idx` (0 to 17) picks the bit position, with index 0 being bit 0.
- R3: The falling edge inside a bit period loads `rd_bit` with the addressed bit. `rd_bit` then holds that value through the low half and the next high half, until the following falling edge.
- R4: When `wr_en` is 1 during a bit period, the rising edge that ends the period stores `wr_bit` into the addressed bit. A read of that bit in the next period returns it.
- R5: A read and a write of the same bit in the same period return the old bit on `rd_bit`. The new value appears only in later periods.
- R6: A write changes only the addressed bit of the addressed word. Every other bit of every word keeps its value.
- R7: When `wr_en` is 0, no stored bit changes, whatever value `wr_bit` carries.
- R8: A `bit_idx` of 18 to 31 reads as 0 and ignores writes even when `wr_en` is 1.
- R9: Reset affects only the output flip-flop. Words written before reset read back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock. The high half is the read phase and the low half is the write phase. |
| rst_n | input | 1 | Asynchronous active-low reset of the output flip-flop. |
| word_sel | input | 3 | Word address, held for the whole bit period. |
| wr_en | input | 1 | Write enable for the current bit period. |
| bit_idx | input | 5 | Bit-time index; selects the bit position. |
| wr_bit | input | 1 | Serial bit to store, sampled at the rising edge that ends the period. |
| rd_bit | output | 1 | Registered serial read bit, updated on the falling edge. |

## Verification
The bound checker keeps a shadow copy of every written bit. On every cycle it checks that the bit presented at the end of a period matches that copy. This covers read-before-write, writes that touch only their own bit, and writes with enable low. On every cycle it also checks that out-of-range indices read as zero and that the output is clear during reset. Three behaviours need the bench's scenarios instead. The first is that the output holds across the high half before the next falling edge. The second is that reset clears the output asynchronously, partway through a period. The third is that stored words survive a reset, which needs a complete readback sweep to see.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   localparam int unsigned RFS_WORDS_DEF = 8;
   localparam int unsigned RFS_BITS_DEF  = 18;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rfs_onehot_dec.sv
module rfs_onehot_dec #(
   parameter int unsigned N     = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N-1:0]     hot
);
   // one lane per position; codes at or above N light nothing
   for (genvar g = 0; g < N; g++) begin : g_lane
      assign hot[g] = (sel == SEL_W'(g));
   end
endmodule

// File: rtl/rfs_word.sv
module rfs_word #(
   parameter int unsigned WORD_BITS = 18
) (
   input  logic                 clk,
   input  logic                 word_we,
   input  logic [WORD_BITS-1:0] lane,
   input  logic                 din,
   output logic [WORD_BITS-1:0] q
);
   // each bit cell commits at the rising edge closing the period
   for (genvar b = 0; b < WORD_BITS; b++) begin : g_cell
      always_ff @(posedge clk) begin
         if (word_we && lane[b]) q[b] <= din;
      end
   end
endmodule

// File: rtl/rfs_read_sel.sv
module rfs_read_sel #(
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned WORD_BITS = 18
) (
   input  logic [NUM_WORDS-1:0][WORD_BITS-1:0] words,
   input  logic [NUM_WORDS-1:0]                word_hot,
   input  logic [WORD_BITS-1:0]                lane,
   output logic                                bit_out
);
   logic [NUM_WORDS-1:0] per_word;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign per_word[w] = word_hot[w] & (|(words[w] & lane));
   end

   assign bit_out = |per_word;
endmodule

// File: rtl/serial_regfile_split.sv
module serial_regfile_split
   import rfs_pkg::*;
#(
   parameter int unsigned NUM_WORDS = RFS_WORDS_DEF,
   parameter int unsigned WORD_BITS = RFS_BITS_DEF,
   localparam int unsigned ADDR_W   = sel_width(NUM_WORDS),
   localparam int unsigned IDX_W    = sel_width(WORD_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] word_sel,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              wr_bit,
   output logic              rd_bit
);
   // elaboration-time parameter checks
   if (NUM_WORDS < 2) begin : g_bad_words
      $error("serial_regfile_split: NUM_WORDS must be at least 2");
   end
   if (WORD_BITS < 2) begin : g_bad_bits
      $error("serial_regfile_split: WORD_BITS must be at least 2");
   end

   logic [NUM_WORDS-1:0]                word_hot;
   logic [WORD_BITS-1:0]                lane;
   logic [NUM_WORDS-1:0][WORD_BITS-1:0] words;
   logic                                rd_comb;

   rfs_onehot_dec #(.N(NUM_WORDS), .SEL_W(ADDR_W)) u_word_dec (
      .sel (word_sel),
      .hot (word_hot)
   );

   rfs_onehot_dec #(.N(WORD_BITS), .SEL_W(IDX_W)) u_lane_dec (
      .sel (bit_idx),
      .hot (lane)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_store
      rfs_word #(.WORD_BITS(WORD_BITS)) u_word (
         .clk     (clk),
         .word_we (wr_en & word_hot[w]),
         .lane    (lane),
         .din     (wr_bit),
         .q       (words[w])
      );
   end

   // read phase: array is sampled while clk is high
   rfs_read_sel #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_rd (
      .words    (words),
      .word_hot (word_hot),
      .lane     (lane),
      .bit_out  (rd_comb)
   );

   // falling edge closes the read phase; storage still holds the old bit
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) rd_bit <= 1'b0;
      else        rd_bit <= rd_comb;
   end
endmodule

// File: rtl/rfs_chk.sv
module rfs_chk #(
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned WORD_BITS = 18,
   localparam int unsigned ADDR_W   = rfs_pkg::sel_width(NUM_WORDS),
   localparam int unsigned IDX_W    = rfs_pkg::sel_width(WORD_BITS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] word_sel,
   input logic              wr_en,
   input logic [IDX_W-1:0]  bit_idx,
   input logic              wr_bit,
   input logic              rd_bit
);
   logic [NUM_WORDS-1:0][WORD_BITS-1:0] sh_val = '0;
   logic [NUM_WORDS-1:0][WORD_BITS-1:0] sh_ok  = '0;
   logic captured  = 1'b0;
   logic rst_seen  = 1'b0;
   logic addr_ok;

   assign addr_ok = (int'(word_sel) < NUM_WORDS) && (int'(bit_idx) < WORD_BITS);

   always_ff @(posedge clk) begin
      if (wr_en && addr_ok) begin
         sh_val[word_sel][bit_idx] <= wr_bit;
         sh_ok[word_sel][bit_idx]  <= 1'b1;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) captured <= 1'b0;
      else        captured <= 1'b1;
   end

   always_ff @(negedge clk) begin
      if (!rst_n) rst_seen <= 1'b1;
   end

   // R1
   out_clear_in_reset_chk: assert property (@(posedge clk)
      (!rst_n && rst_seen) |-> (rd_bit == 1'b0));

   // R5 R6 R7
   shadow_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (captured && addr_ok && sh_ok[word_sel][bit_idx])
         |-> (rd_bit == sh_val[word_sel][bit_idx]));

   // R8
   range_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (captured && int'(bit_idx) >= WORD_BITS) |-> (rd_bit == 1'b0));

   // R4
   write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (captured && wr_en && addr_ok)
         |=> (!($stable(word_sel) && $stable(bit_idx)) || (rd_bit == $past(wr_bit))));
endmodule

bind serial_regfile_split rfs_chk #(
   .NUM_WORDS (NUM_WORDS),
   .WORD_BITS (WORD_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .word_sel (word_sel),
   .wr_en    (wr_en),
   .bit_idx  (bit_idx),
   .wr_bit   (wr_bit),
   .rd_bit   (rd_bit)
);

// File: tb/serial_regfile_split_test.sv
module serial_regfile_split_test;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 8;
   localparam int NB = 18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] word_sel = '0;
   logic       wr_en = 1'b0;
   logic [4:0] bit_idx = '0;
   logic       wr_bit = 1'b0;
   logic       rd_bit;

   int checks = 0;
   int fails  = 0;
   logic [NB-1:0] model [NW];
   logic early;
   logic prev_got;

   serial_regfile_split uut (
      .clk(clk), .rst_n(rst_n), .word_sel(word_sel), .wr_en(wr_en),
      .bit_idx(bit_idx), .wr_bit(wr_bit), .rd_bit(rd_bit)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
      end
   endtask

   // one bit period: drive after the rising edge, sample after the falling edge
   task automatic xfer(input int w, input int i, input logic we, input logic d,
                       output logic got);
      @(posedge clk);
      #1;
      word_sel = 3'(w);
      bit_idx  = 5'(i);
      wr_en    = we;
      wr_bit   = d;
      early    = rd_bit;
      @(negedge clk);
      #2;
      got = rd_bit;
      if (we && i < NB) model[w][i] = d;
   endtask

   task automatic readback(input string req);
      logic g;
      for (int w = 0; w < NW; w++) begin
         for (int i = 0; i < NB; i++) begin
            xfer(w, i, 1'b0, ~model[w][i], g);
            chk(req, g, model[w][i]);
            if (w != 0 || i != 0) chk("R3 hold before fall", early, prev_got);
            prev_got = g;
         end
      end
   endtask

   function automatic logic [NB-1:0] pat(input int w);
      return NB'((w * 32'h0A5B3 + 32'h13579) ^ (w << 9));
   endfunction

   initial begin
      logic g;
      logic old;
      int pw [4];
      int pi [4];
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset output", rd_bit, 1'b0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R2 R4: load every word serially
      for (int w = 0; w < NW; w++)
         for (int i = 0; i < NB; i++)
            xfer(w, i, 1'b1, pat(w)[i], g);
      xfer(0, 0, 1'b0, 1'b1, g);
      chk("R4 first bit after load", g, model[0][0]);
      prev_got = g;
      readback("R2 R7 readback");

      // R5 then R4 at corner positions
      pw = '{3, 3, 6, 0};
      pi = '{0, 17, 9, 5};
      for (int k = 0; k < 4; k++) begin
         old = model[pw[k]][pi[k]];
         xfer(pw[k], pi[k], 1'b1, ~old, g);
         chk("R5 read before write", g, old);
         xfer(pw[k], pi[k], 1'b0, old, g);
         chk("R4 written value", g, ~old);
      end

      // R5 back-to-back in-place complement of one word
      for (int i = 0; i < NB; i++) begin
         old = model[5][i];
         xfer(5, i, 1'b1, ~old, g);
         chk("R5 in-place sweep", g, old);
      end
      xfer(0, 0, 1'b0, 1'b0, g);
      prev_got = g;
      readback("R6 other bits kept");

      // R8 out-of-range index
      for (int i = NB; i < 32; i++) begin
         xfer(2, i, 1'b1, i[0], g);
         chk("R8 range read zero", g, 1'b0);
      end
      xfer(2, 0, 1'b0, 1'b0, g);
      prev_got = g;
      readback("R8 range write ignored");

      // R1 R9: asynchronous reset with a 1 on the output
      model[4][7] = 1'b1;
      xfer(4, 7, 1'b1, 1'b1, g);
      xfer(4, 7, 1'b0, 1'b0, g);
      chk("R4 set before reset", g, 1'b1);
      rst_n = 1'b0;
      #1;
      chk("R1 async clear", rd_bit, 1'b0);
      repeat (3) @(negedge clk);
      #1;
      chk("R1 held in reset", rd_bit, 1'b0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      xfer(0, 0, 1'b0, 1'b0, g);
      prev_got = g;
      readback("R9 store survives reset");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule